// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block puts two eight-input priority interrupt controllers behind a single interrupt output. Sixteen request lines come in. Line n is routed to controller n>>3 at input n&7, so lines 0 to 7 go to the master and lines 8 to 15 go to the slave. Whenever the slave has a request that wins arbitration, that request is latched into master input 2 as an edge-style request. The master's arbitration result alone drives the interrupt output.

A processor reaches the block through byte-wide I/O reads and writes. The master's command and data ports sit at 0x20 and 0x21, and the slave's at 0xA0 and 0xA1. Address bit 7 picks the controller and address bit 0 picks the port. Two trigger-mode registers sit at 0x4D0 (master) and 0x4D1 (slave). An acknowledge strobe produces an 8-bit vector one cycle later, and the cascade path is resolved inside the block.

Each controller supports:
- an initialization sequence that loads its vector base and its options;
- masking of inputs;
- rotating priority;
- end-of-interrupt commands;
- polling;
- auto end-of-interrupt.

The master also has a nested mode that lets slave interrupts nest while master input 2 is in service.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Line n feeds controller n>>3 at input n&7. In edge mode, a rising level sets that input's request. An unmasked request that outranks everything in service raises int_out.
- R2: A write to 0x4D0 stores the data ANDed with 0xF8, and a write to 0x4D1 stores the data ANDed with 0xDE. Both registers read back. A set bit makes its input level-triggered. A level-triggered request follows the line, and it stays set through an acknowledge.
- R3: A command-port write with bit 4 set starts initialization and clears mask, request, in-service and priority state. The next data write sets the vector base to data & 0xF8. The write after that is taken without effect. If bit 0 of the starting write was 1, one more data write follows. In that write, bit 4 selects nested mode and bit 1 selects auto end-of-interrupt. After the sequence, data-port writes load the mask.
- R4: The mask sits at the data port, reads back there, and is zero after reset. A masked input never raises int_out, although its request bit is still recorded.
- R5: vec_valid pulses exactly one cycle after ack_req. The vector is master base + master input when the master winner is not input 2. The acknowledged input moves to in-service and its edge request clears. An edge arriving in the acknowledge cycle is kept.
- R6: When the master winner is input 2, the slave's winner is acknowledged as well, and the vector is slave base + slave input.
- R7: With no master winner the vector is master base + 7. When the master winner is input 2 but the slave has no winner, the vector is slave base + 7.
- R8: After reset, input 0 has the highest priority and input 7 the lowest. An input in service blocks requests of equal or lower priority.
- R9: A command-port write with bits 4 and 3 clear is decoded by bits 7:5. Code 001 clears the highest-priority in-service bit. Code 011 clears in-service bit data[2:0]. Code 110 makes data[2:0] the lowest priority. Code 101 clears like 001 and then rotates. Code 111 clears like 011 and then rotates.
- R10: In nested mode the master leaves in-service bit 2 out of its current-priority figure. A higher-priority slave request can therefore interrupt a slave interrupt already being serviced.
- R11: A command-port write with bit 3 set and bit 4 clear is a read-select and poll command. Bit 1 with bit 0 selects the in-service register for command-port reads, and bit 1 alone selects the request register. Bit 2 arms a poll. The next read of that controller returns the winning input, or 7 if there is none, and clears that input's request and in-service bits. A slave poll that finds a winner also clears master request and in-service bit 2.
- R12: io_rdata is valid with io_rd_valid one cycle after io_rd. A read of an unmapped address returns 0x00. A write to an unmapped address is ignored. An access with io_len other than 1 is ignored.
- R13: With auto end-of-interrupt, an acknowledge does not set the in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Interrupt request lines |
| io_addr | input | ADDR_W | I/O address |
| io_len | input | 3 | Access size in bytes; only 1 is accepted |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| io_rd_valid | output | 1 | Read data valid, one cycle after io_rd |
| ack_req | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector valid, one cycle after ack_req |
| vec_out | output | 8 | Interrupt vector |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Two collisions are exercised. In the first, an acknowledge lands in the same cycle as a fresh edge on another master line. The bench raises the new line on the very clock that carries ack_req. It then expects the first vector, a quiet output while that input is in service, and the second vector after the end-of-interrupt. In the second, the master acknowledges its cascade input in the same cycle that the slave still shows its old winner. The nested-mode sequence checks that the cascade request is not set again by the request just taken, while a newer higher-priority slave request still reaches the master and produces its own vector.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;

    localparam int CORE_IN = 8;
    localparam int IDX_W   = $clog2(CORE_IN);
    localparam int CASC_IN = 2;
    localparam int SPUR_IN = CORE_IN - 1;
    localparam int BASE_W  = 8 - IDX_W;
    localparam logic [IDX_W:0] NO_PRIO = (IDX_W + 1)'(CORE_IN);

    typedef enum logic [1:0] {
        INI_IDLE,
        INI_BASE,
        INI_W3,
        INI_W4
    } init_e;

    typedef struct packed {
        logic [CORE_IN-1:0] irr;
        logic [CORE_IN-1:0] imr;
        logic [CORE_IN-1:0] isr;
        logic [CORE_IN-1:0] last;
        logic [CORE_IN-1:0] trig;
        logic [BASE_W-1:0]  base;
        logic [IDX_W-1:0]   add;
        init_e              ini;
        logic               need4;
        logic               aeoi;
        logic               rot_aeoi;
        logic               sfnm;
        logic               rsel;
        logic               poll;
    } core_st_t;

    typedef enum logic [2:0] {
        T_NONE,
        T_MASTER,
        T_SLAVE,
        T_TRIG_M,
        T_TRIG_S
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic port;
        logic wr;
        logic rd;
    } acc_t;

    // Rank of the highest-priority set bit after rotation; NO_PRIO if none.
    function automatic logic [IDX_W:0] top_prio(input logic [CORE_IN-1:0] m,
                                                 input logic [IDX_W-1:0] add);
        logic [IDX_W:0]   res;
        logic [IDX_W-1:0] idx;
        res = NO_PRIO;
        for (int i = CORE_IN - 1; i >= 0; i--) begin
            idx = IDX_W'(i) + add;
            if (m[idx]) res = (IDX_W + 1)'(i);
        end
        return res;
    endfunction

endpackage

// File: rtl/irq_port_decode.sv
module irq_port_decode
    import irq_casc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] M_PORT = 'h20,
    parameter logic [ADDR_W-1:0] S_PORT = 'hA0,
    parameter logic [ADDR_W-1:0] T_PORT = 'h4D0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        len,
    input  logic              wr,
    input  logic              rd,
    output acc_t              acc
);
    logic byte_ok;
    logic [ADDR_W-2:0] hi;

    always_comb begin
        byte_ok  = (len == 3'd1);
        hi       = addr[ADDR_W-1:1];
        acc.port = addr[0];
        acc.wr   = wr && byte_ok;
        acc.rd   = rd && byte_ok;
        if (hi == M_PORT[ADDR_W-1:1])      acc.tgt = T_MASTER;
        else if (hi == S_PORT[ADDR_W-1:1]) acc.tgt = T_SLAVE;
        else if (hi == T_PORT[ADDR_W-1:1]) acc.tgt = addr[0] ? T_TRIG_S : T_TRIG_M;
        else                               acc.tgt = T_NONE;
    end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
    import irq_casc_pkg::*;
#(
    parameter logic [CORE_IN-1:0] TRIG_MASK = 8'hF8,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CORE_IN-1:0] line_in,
    input  logic               casc_set,
    input  logic               casc_clr,
    input  logic               cmd_wr,
    input  logic               dat_wr,
    input  logic               trig_wr,
    input  logic [7:0]         wdata,
    input  logic               rd_en,
    input  logic               rd_port,
    input  logic               ack_en,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_id,
    output logic [BASE_W-1:0]  vec_base,
    output logic [7:0]         rd_val,
    output logic [7:0]         trig_val,
    output logic               poll_hit
);
    core_st_t st, nx;
    logic [CORE_IN-1:0] req, svc;
    logic [IDX_W:0]     p_req, p_svc, p_eoi;
    logic [IDX_W-1:0]   eoi_id;

    // Arbitration over the registered state
    always_comb begin
        req = st.irr & ~st.imr;
        svc = st.isr;
        if (IS_MASTER && st.sfnm) svc[CASC_IN] = 1'b0;
        p_req     = top_prio(req, st.add);
        p_svc     = top_prio(svc, st.add);
        win_valid = (p_req != NO_PRIO) && (p_req < p_svc);
        win_id    = p_req[IDX_W-1:0] + st.add;
    end

    assign vec_base = st.base;
    assign trig_val = st.trig;
    assign poll_hit = rd_en && st.poll && win_valid;

    always_comb begin
        if (st.poll)       rd_val = win_valid ? {{(8-IDX_W){1'b0}}, win_id} : 8'(SPUR_IN);
        else if (rd_port)  rd_val = st.imr;
        else if (st.rsel)  rd_val = st.isr;
        else               rd_val = st.irr;
    end

    always_comb begin
        nx     = st;
        p_eoi  = '0;
        eoi_id = '0;
        // acknowledge first, so an edge in the same cycle survives
        if (ack_en && win_valid) begin
            if (st.aeoi) begin
                if (st.rot_aeoi) nx.add = win_id + 1'b1;
            end else begin
                nx.isr[win_id] = 1'b1;
            end
            if (!st.trig[win_id]) nx.irr[win_id] = 1'b0;
        end
        // line sampling
        for (int i = 0; i < CORE_IN; i++) begin
            if (st.trig[i])                    nx.irr[i] = line_in[i];
            else if (line_in[i] && !st.last[i]) nx.irr[i] = 1'b1;
        end
        nx.last = line_in;
        if (casc_set) nx.irr[CASC_IN] = 1'b1;
        // poll read
        if (rd_en && st.poll) begin
            nx.poll = 1'b0;
            if (win_valid) begin
                nx.irr[win_id] = 1'b0;
                nx.isr[win_id] = 1'b0;
            end
        end
        if (trig_wr) nx.trig = wdata & TRIG_MASK;
        if (dat_wr) begin
            unique case (st.ini)
                INI_IDLE: nx.imr = wdata;
                INI_BASE: begin
                    nx.base = wdata[7:IDX_W];
                    nx.ini  = INI_W3;
                end
                INI_W3:   nx.ini = st.need4 ? INI_W4 : INI_IDLE;
                INI_W4: begin
                    nx.sfnm = wdata[4];
                    nx.aeoi = wdata[1];
                    nx.ini  = INI_IDLE;
                end
            endcase
        end
        if (cmd_wr && !wdata[4]) begin
            if (wdata[3]) begin
                if (wdata[2]) nx.poll = 1'b1;
                if (wdata[1]) nx.rsel = wdata[0];
            end else begin
                unique case (wdata[7:5])
                    3'b000, 3'b100: nx.rot_aeoi = wdata[7];
                    3'b001, 3'b101: begin
                        p_eoi = top_prio(nx.isr, nx.add);
                        if (p_eoi != NO_PRIO) begin
                            eoi_id = p_eoi[IDX_W-1:0] + nx.add;
                            nx.isr[eoi_id] = 1'b0;
                            if (wdata[7]) nx.add = eoi_id + 1'b1;
                        end
                    end
                    3'b011: nx.isr[wdata[IDX_W-1:0]] = 1'b0;
                    3'b110: nx.add = wdata[IDX_W-1:0] + 1'b1;
                    3'b111: begin
                        nx.isr[wdata[IDX_W-1:0]] = 1'b0;
                        nx.add = wdata[IDX_W-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        if (casc_clr) begin
            nx.irr[CASC_IN] = 1'b0;
            nx.isr[CASC_IN] = 1'b0;
        end
        if (cmd_wr && wdata[4]) begin
            nx       = '0;
            nx.trig  = st.trig;
            nx.ini   = INI_BASE;
            nx.need4 = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    // R5
    isr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_en && win_valid && !st.aeoi && !cmd_wr && !casc_clr && !rd_en)
        |=> st.isr[$past(win_id)]);

    // R13
    aeoi_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_en && win_valid && st.aeoi && !st.isr[win_id])
        |=> !st.isr[$past(win_id)]);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_casc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] M_PORT = 'h20,
    parameter logic [ADDR_W-1:0] S_PORT = 'hA0,
    parameter logic [ADDR_W-1:0] T_PORT = 'h4D0,
    parameter logic [7:0] M_TRIG_MASK = 8'hF8,
    parameter logic [7:0] S_TRIG_MASK = 8'hDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       irq_lines,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [2:0]        io_len,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rd_valid,
    input  logic              ack_req,
    output logic              vec_valid,
    output logic [7:0]        vec_out,
    output logic              int_out
);
    localparam int LINES = 2 * CORE_IN;

    acc_t acc;
    logic m_win, s_win, s_poll_hit, m_poll_hit, casc_set, ack_casc;
    logic [IDX_W-1:0]  m_id, s_id;
    logic [BASE_W-1:0] m_base, s_base;
    logic [7:0] m_rd, s_rd, m_trig, s_trig, rd_mux, vec_nx;
    logic [LINES-1:0] lines;

    assign lines = irq_lines;

    irq_port_decode #(
        .ADDR_W(ADDR_W), .M_PORT(M_PORT), .S_PORT(S_PORT), .T_PORT(T_PORT)
    ) u_dec (
        .addr(io_addr), .len(io_len), .wr(io_wr), .rd(io_rd), .acc(acc)
    );

    assign ack_casc = ack_req && m_win && (m_id == IDX_W'(CASC_IN));
    assign casc_set = s_win && !ack_casc;

    irq_ctrl_core #(.TRIG_MASK(M_TRIG_MASK), .IS_MASTER(1'b1)) u_master (
        .clk(clk), .rst(rst),
        .line_in(lines[CORE_IN-1:0]),
        .casc_set(casc_set),
        .casc_clr(s_poll_hit),
        .cmd_wr(acc.wr && acc.tgt == T_MASTER && !acc.port),
        .dat_wr(acc.wr && acc.tgt == T_MASTER && acc.port),
        .trig_wr(acc.wr && acc.tgt == T_TRIG_M),
        .wdata(io_wdata),
        .rd_en(acc.rd && acc.tgt == T_MASTER),
        .rd_port(acc.port),
        .ack_en(ack_req),
        .win_valid(m_win), .win_id(m_id), .vec_base(m_base),
        .rd_val(m_rd), .trig_val(m_trig), .poll_hit(m_poll_hit)
    );

    irq_ctrl_core #(.TRIG_MASK(S_TRIG_MASK), .IS_MASTER(1'b0)) u_slave (
        .clk(clk), .rst(rst),
        .line_in(lines[LINES-1:CORE_IN]),
        .casc_set(1'b0),
        .casc_clr(1'b0),
        .cmd_wr(acc.wr && acc.tgt == T_SLAVE && !acc.port),
        .dat_wr(acc.wr && acc.tgt == T_SLAVE && acc.port),
        .trig_wr(acc.wr && acc.tgt == T_TRIG_S),
        .wdata(io_wdata),
        .rd_en(acc.rd && acc.tgt == T_SLAVE),
        .rd_port(acc.port),
        .ack_en(ack_casc),
        .win_valid(s_win), .win_id(s_id), .vec_base(s_base),
        .rd_val(s_rd), .trig_val(s_trig), .poll_hit(s_poll_hit)
    );

    assign int_out = m_win;

    always_comb begin
        rd_mux = 8'h00;
        if (acc.rd) begin
            unique case (acc.tgt)
                T_MASTER: rd_mux = m_rd;
                T_SLAVE:  rd_mux = s_rd;
                T_TRIG_M: rd_mux = m_trig;
                T_TRIG_S: rd_mux = s_trig;
                default:  rd_mux = 8'h00;
            endcase
        end
        if (!m_win)        vec_nx = {m_base, IDX_W'(SPUR_IN)};
        else if (!ack_casc) vec_nx = {m_base, m_id};
        else if (s_win)    vec_nx = {s_base, s_id};
        else               vec_nx = {s_base, IDX_W'(SPUR_IN)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata    <= '0;
            io_rd_valid <= 1'b0;
            vec_out     <= '0;
            vec_valid   <= 1'b0;
        end else begin
            io_rdata    <= rd_mux;
            io_rd_valid <= io_rd;
            vec_valid   <= ack_req;
            if (ack_req) vec_out <= vec_nx;
        end
    end

    // R5
    vec_timing_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack_req));

    // R7
    spur_master_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !m_win) |=> (vec_out[IDX_W-1:0] == IDX_W'(SPUR_IN)));

    // R6
    casc_vec_chk: assert property (@(posedge clk) disable iff (rst)
        ack_casc |=> (vec_out[7:IDX_W] == $past(s_base)));

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && acc.tgt == T_NONE) |=> (io_rdata == 8'h00));

    // R2
    trig_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.tgt == T_TRIG_M) |=> ((io_rdata & ~M_TRIG_MASK) == 8'h00));
endmodule

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {line number, expected vector}
    localparam logic [11:0] VEC_TBL [NVEC] = '{
        {4'd0, 8'h20}, {4'd5, 8'h25}, {4'd9, 8'h71},
        {4'd15, 8'h77}, {4'd3, 8'h23}, {4'd12, 8'h74}
    };

    logic clk = 1'b0;
    logic rst;
    logic [15:0] irq_lines;
    logic [15:0] io_addr;
    logic [2:0]  io_len;
    logic        io_wr, io_rd, ack_req;
    logic [7:0]  io_wdata, io_rdata, vec_out;
    logic        io_rd_valid, vec_valid, int_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_cascade_ctrl uut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .io_addr(io_addr), .io_len(io_len), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_valid(io_rd_valid),
        .ack_req(ack_req), .vec_valid(vec_valid), .vec_out(vec_out),
        .int_out(int_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] len = 3'd1);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_len = len; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_len = 3'd1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        v = vec_valid ? vec_out : 8'hXX;
    endtask

    task automatic init_master(input logic [7:0] opt);
        wr(16'h0020, 8'h11); wr(16'h0021, 8'h20); wr(16'h0021, 8'h04); wr(16'h0021, opt);
    endtask

    task automatic init_slave();
        wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h70); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [3:0] ln;
        rst = 1'b1; irq_lines = '0; io_addr = '0; io_len = 3'd1;
        io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0; ack_req = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // reset state
        chk("R8 reset int_out", {7'd0, int_out}, 8'h00);
        rd(16'h0021, d); chk("R4 reset mask", d, 8'h00);
        chk("R12 rd_valid", {7'd0, io_rd_valid}, 8'h01);
        do_ack(d); chk("R7 spurious master vector", d, 8'h07);

        init_master(8'h01);
        init_slave();

        // R1 R3 R5 R6 R9: vector table
        for (int k = 0; k < NVEC; k++) begin
            ln = VEC_TBL[k][11:8];
            irq_lines[ln] = 1'b1;
            wait_n(3);
            chk("R1 line raises int_out", {7'd0, int_out}, 8'h01);
            do_ack(d);
            chk("R5 R6 R3 vector", d, VEC_TBL[k][7:0]);
            irq_lines[ln] = 1'b0;
            if (ln >= 4'd8) wr(16'h00A0, 8'h20);
            wr(16'h0020, 8'h20);
            wait_n(2);
            chk("R9 eoi quiets int_out", {7'd0, int_out}, 8'h00);
        end

        // R8 priority and in-service blocking
        irq_lines[4] = 1'b1; irq_lines[6] = 1'b1;
        wait_n(2);
        do_ack(d); chk("R8 higher wins", d, 8'h24);
        wait_n(1);
        chk("R8 in-service blocks", {7'd0, int_out}, 8'h00);
        wr(16'h0020, 8'h20);
        wait_n(1);
        do_ack(d); chk("R8 lower after eoi", d, 8'h26);
        wr(16'h0020, 8'h20);
        irq_lines[4] = 1'b0; irq_lines[6] = 1'b0;

        // R9 rotation
        wr(16'h0020, 8'hC3);
        irq_lines[1] = 1'b1; irq_lines[5] = 1'b1;
        wait_n(2);
        do_ack(d); chk("R9 rotated winner", d, 8'h25);
        wr(16'h0020, 8'h65);
        wait_n(1);
        do_ack(d); chk("R9 specific eoi", d, 8'h21);
        wr(16'h0020, 8'h20);
        wr(16'h0020, 8'hC7);
        irq_lines[1] = 1'b0; irq_lines[5] = 1'b0;
        wait_n(2);

        // R5 collision: new edge during the acknowledge cycle
        irq_lines[1] = 1'b1;
        wait_n(2);
        @(negedge clk);
        ack_req = 1'b1; irq_lines[7] = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R5 ack with new edge", vec_out, 8'h21);
        wr(16'h0020, 8'h20);
        wait_n(1);
        chk("R5 new edge kept", {7'd0, int_out}, 8'h01);
        do_ack(d); chk("R5 second vector", d, 8'h27);
        wr(16'h0020, 8'h20);
        irq_lines[1] = 1'b0; irq_lines[7] = 1'b0;

        // R7 spurious slave
        irq_lines[9] = 1'b1;
        wait_n(3);
        wr(16'h00A1, 8'h02);
        do_ack(d); chk("R7 spurious slave vector", d, 8'h77);
        wr(16'h0020, 8'h20);
        wr(16'h00A1, 8'h00);
        wait_n(3);
        do_ack(d); chk("R6 slave after unmask", d, 8'h71);
        wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
        irq_lines[9] = 1'b0;
        wait_n(2);

        // R2 trigger mode
        wr(16'h04D0, 8'hFF); rd(16'h04D0, d); chk("R2 master trig mask", d, 8'hF8);
        wr(16'h04D1, 8'hFF); rd(16'h04D1, d); chk("R2 slave trig mask", d, 8'hDE);
        wr(16'h04D1, 8'h00);
        irq_lines[3] = 1'b1;
        wait_n(2);
        do_ack(d); chk("R2 level vector", d, 8'h23);
        wr(16'h0020, 8'h20);
        wait_n(1);
        chk("R2 level survives ack", {7'd0, int_out}, 8'h01);
        irq_lines[3] = 1'b0;
        wait_n(2);
        chk("R2 level follows line", {7'd0, int_out}, 8'h00);
        wr(16'h04D0, 8'h00);

        // R4 mask
        wr(16'h0021, 8'h01);
        irq_lines[0] = 1'b1;
        wait_n(2);
        chk("R4 masked quiet", {7'd0, int_out}, 8'h00);
        rd(16'h0021, d); chk("R4 mask readback", d, 8'h01);
        rd(16'h0020, d); chk("R11 request register read", d, 8'h01);
        wr(16'h0021, 8'h00);
        wait_n(1);
        do_ack(d); chk("R4 unmasked vector", d, 8'h20);
        wr(16'h0020, 8'h20);
        irq_lines[0] = 1'b0;

        // R11 in-service read and poll
        irq_lines[6] = 1'b1;
        wait_n(2);
        do_ack(d);
        wr(16'h0020, 8'h0B);
        rd(16'h0020, d); chk("R11 in-service read", d, 8'h40);
        wr(16'h0020, 8'h20); wr(16'h0020, 8'h0A);
        irq_lines[6] = 1'b0;
        irq_lines[10] = 1'b1;
        wait_n(3);
        wr(16'h00A0, 8'h0C);
        rd(16'h00A0, d); chk("R11 slave poll value", d, 8'h02);
        wait_n(1);
        chk("R11 slave poll clears cascade", {7'd0, int_out}, 8'h00);
        wr(16'h0020, 8'h0C);
        rd(16'h0020, d); chk("R11 empty poll", d, 8'h07);
        irq_lines[10] = 1'b0;

        // R10 nested mode
        init_master(8'h11);
        irq_lines[9] = 1'b1;
        wait_n(3);
        do_ack(d); chk("R10 first slave vector", d, 8'h71);
        wait_n(1);
        chk("R10 no re-raise after cascade ack", {7'd0, int_out}, 8'h00);
        irq_lines[8] = 1'b1;
        wait_n(3);
        chk("R10 nested slave raises", {7'd0, int_out}, 8'h01);
        do_ack(d); chk("R10 nested vector", d, 8'h70);
        wr(16'h00A0, 8'h20); wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
        irq_lines[8] = 1'b0; irq_lines[9] = 1'b0;

        // R13 auto end-of-interrupt
        init_master(8'h03);
        irq_lines[4] = 1'b1;
        wait_n(2);
        do_ack(d); chk("R13 aeoi vector", d, 8'h24);
        wr(16'h0020, 8'h0B);
        rd(16'h0020, d); chk("R13 no in-service", d, 8'h00);
        irq_lines[4] = 1'b0;
        init_master(8'h01);

        // R12 unmapped and non-byte
        wr(16'h0021, 8'hFF, 3'd2);
        rd(16'h0021, d); chk("R12 non-byte write ignored", d, 8'h00);
        wr(16'h0022, 8'hFF);
        rd(16'h0022, d); chk("R12 unmapped read", d, 8'h00);
        rd(16'h0021, d); chk("R12 unmapped write ignored", d, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule